// File: doc/BRIEF.md
# Serial Audio Port Control Word and PCM-Domain Sequencer

This block is the control and status word of a serial audio port. It lives in the host bus clock domain and drives a separate PCM bit-clock domain. A single 32-bit word holds the port controls: enable, the independent transmit and receive run bits, DMA enable, FIFO thresholds, FIFO clear requests, a sync bit and the standby release. The same word returns FIFO level flags, sticky error flags and the sync echo. The FIFOs, the serial framer and the DMA engine sit outside the block and exchange only levels and pulses with it.

FIFO clear requests cross into the PCM domain through a toggle handshake. Each direction has a clear lane with a PCM-side machine. Its states are `CL_IDLE`, `CL_WAIT` and `CL_FIRE`. The transitions are: request seen (`CL_IDLE`→`CL_WAIT`), settle count done (`CL_WAIT`→`CL_FIRE`) and acknowledge (`CL_FIRE`→`CL_IDLE`). In `CL_FIRE` the lane emits a one-cycle clear pulse and returns the toggle, and the host then drops the request bit by itself.

The standby release runs through a wake machine with the states `WK_SLEEP`, `WK_COUNT` and `WK_READY`. The transitions are: release seen (`WK_SLEEP`→`WK_COUNT`), count done (`WK_COUNT`→`WK_READY`) and release withdrawn (`WK_COUNT`/`WK_READY`→`WK_SLEEP`). The sync bit makes a round trip through the PCM domain and back, so software can toggle it and poll until the echo changes. That change proves the PCM clock is running.

Top module: `pcm_ctrl_sync`

## Requirements
- R1: After reset, with all status inputs low, `rd_data` reads 0, every control output is 0 and `pcm_ready` is 0.
- R2: A write drives the control outputs from the following fields, and they read back unchanged from the next host cycle on: bit 0 port enable, bit 1 receive run, bit 2 transmit run, bits 6:5 transmit threshold, bits 8:7 receive threshold, bit 9 DMA enable.
- R3: The transmit and receive run bits are independent. Clearing one leaves the other running.
- R4: Writing 1 to bit 3 (transmit) or bit 4 (receive) sets that bit on read from the next host cycle on. One single-PCM-cycle clear pulse follows on `pcm_tx_clr` or `pcm_rx_clr`, no sooner than 2 PCM clock edges after the write. The bit then reads 0 again without software action. Writing 0 to these bits produces no pulse.
- R5: While the PCM clock is stopped, a pending clear bit stays 1 and no pulse occurs. The clear completes once the clock resumes.
- R6: A value written to bit 24 reads back only after crossing into the PCM domain and back, which takes at least 2 PCM clock edges. While the PCM clock is stopped, the readback does not change.
- R7: After bit 25 is set, `pcm_ready` rises only after the release has been synchronized and then held for WAKE_CYCLES (default 4) PCM cycles. It falls once a cleared bit 25 reaches the PCM domain.
- R8: The status inputs read back on their own bits: 13 transmit sync, 14 receive sync, 17 transmit needs data, 18 receive needs reading, 19 transmit has room, 20 receive holds data, 21 transmit empty, 22 receive full.
- R9: Bit 15 (transmit error) is set by `tx_underflow` and bit 16 (receive error) by `rx_overflow`, each only while the port is enabled and that direction runs. Each flag is sticky and is cleared by writing 1 to it. Writing 0 keeps it. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Control and status readback |
| port_en | output | 1 | Port enable |
| rx_on | output | 1 | Receive run |
| tx_on | output | 1 | Transmit run |
| dma_en | output | 1 | DMA request enable |
| rx_thresh | output | 2 | Receive DMA threshold |
| tx_thresh | output | 2 | Transmit DMA threshold |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_space | input | 1 | Transmit FIFO can accept data |
| txf_low | input | 1 | Transmit FIFO needs writing |
| rxf_data | input | 1 | Receive FIFO holds data |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_high | input | 1 | Receive FIFO needs reading |
| tx_syncd | input | 1 | Transmit side synchronized |
| rx_syncd | input | 1 | Receive side synchronized |
| tx_underflow | input | 1 | Transmit underflow event pulse |
| rx_overflow | input | 1 | Receive overflow event pulse |
| pcm_clk | input | 1 | PCM bit clock |
| pcm_tx_clr | output | 1 | Transmit FIFO clear pulse, PCM domain |
| pcm_rx_clr | output | 1 | Receive FIFO clear pulse, PCM domain |
| pcm_ready | output | 1 | Port out of standby, PCM domain |

## Verification
A clear lane stuck in `CL_WAIT`, or a toggle that never returns, shows at the ports as a clear bit that stays 1 for hundreds of host cycles and as a missing pulse. A machine that skips its count shows as a pulse, or as `pcm_ready`, arriving fewer PCM edges after the write than the bound allows. This is measured within about ten PCM cycles of the write. A broken return path for the sync bit shows as an echo that arrives too early, never arrives, or moves while the PCM clock is stopped. Sticky-flag faults appear on the very next host read.

// File: rtl/pcm_ctrl_pkg.sv
package pcm_ctrl_pkg;
    localparam int WORD_W     = 32;
    localparam int B_EN       = 0;
    localparam int B_RX_RUN   = 1;
    localparam int B_TX_RUN   = 2;
    localparam int B_TX_FLUSH = 3;
    localparam int B_RX_FLUSH = 4;
    localparam int B_TX_THR   = 5;
    localparam int B_RX_THR   = 7;
    localparam int B_DMA      = 9;
    localparam int B_TX_ALIGN = 13;
    localparam int B_RX_ALIGN = 14;
    localparam int B_TX_FAULT = 15;
    localparam int B_RX_FAULT = 16;
    localparam int B_TX_HUNGRY = 17;
    localparam int B_RX_READY = 18;
    localparam int B_TX_ROOM  = 19;
    localparam int B_RX_AVAIL = 20;
    localparam int B_TX_DRY   = 21;
    localparam int B_RX_BRIM  = 22;
    localparam int B_ECHO     = 24;
    localparam int B_WAKE     = 25;

    typedef enum logic [1:0] {CL_IDLE, CL_WAIT, CL_FIRE} clr_state_t;
    typedef enum logic [1:0] {WK_SLEEP, WK_COUNT, WK_READY} wake_state_t;
endpackage

// File: rtl/pcm_bit_sync.sv
module pcm_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pcm_clr_lane.sv
module pcm_clr_lane
    import pcm_ctrl_pkg::*;
#(
    parameter int STAGES     = 2,
    parameter int CLR_CYCLES = 2
) (
    input  logic clk,
    input  logic pcm_clk,
    input  logic rst_n,
    input  logic req,
    output logic pending,
    output logic pcm_clr
);
    localparam int CNT_W = $clog2(CLR_CYCLES + 1);

    logic req_tgl, ack_tgl, ack_s, req_s;
    logic [CNT_W-1:0] cnt;
    clr_state_t state, state_nx;

    // host side: one toggle per accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              req_tgl <= 1'b0;
        else if (req && !pending) req_tgl <= ~req_tgl;
    end

    pcm_bit_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));

    assign pending = req_tgl ^ ack_s;

    pcm_bit_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(pcm_clk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

    // PCM side state register
    always_ff @(posedge pcm_clk or negedge rst_n) begin
        if (!rst_n) state <= CL_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CL_IDLE: if (req_s != ack_tgl) state_nx = CL_WAIT;
            CL_WAIT: if (cnt == CNT_W'(CLR_CYCLES - 1)) state_nx = CL_FIRE;
            CL_FIRE: state_nx = CL_IDLE;
            default: state_nx = CL_IDLE;
        endcase
    end

    always_ff @(posedge pcm_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            ack_tgl <= 1'b0;
        end else begin
            if (state == CL_WAIT) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
            if (state == CL_FIRE) ack_tgl <= req_s;
        end
    end

    // outputs
    always_comb begin
        pcm_clr = (state == CL_FIRE);
    end

    // R4
    clr_single_chk: assert property (@(posedge pcm_clk) disable iff (!rst_n)
        pcm_clr |=> !pcm_clr);
    // R4
    clr_owed_chk: assert property (@(posedge pcm_clk) disable iff (!rst_n)
        pcm_clr |-> (req_s != ack_tgl));
    // R4
    clr_rerequest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && req) |=> $stable(req_tgl));
endmodule

// File: rtl/pcm_wake_fsm.sv
module pcm_wake_fsm
    import pcm_ctrl_pkg::*;
#(
    parameter int STAGES      = 2,
    parameter int WAKE_CYCLES = 4
) (
    input  logic pcm_clk,
    input  logic rst_n,
    input  logic release_lvl,
    output logic ready
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

    logic rel_s;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] held_cnt;
    wake_state_t state, state_nx;

    pcm_bit_sync #(.STAGES(STAGES)) u_rel_sync (
        .clk(pcm_clk), .rst_n(rst_n), .d(release_lvl), .q(rel_s));

    always_ff @(posedge pcm_clk or negedge rst_n) begin
        if (!rst_n) state <= WK_SLEEP;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WK_SLEEP: if (rel_s) state_nx = WK_COUNT;
            WK_COUNT: begin
                if (!rel_s) state_nx = WK_SLEEP;
                else if (cnt == CNT_W'(WAKE_CYCLES - 1)) state_nx = WK_READY;
            end
            WK_READY: if (!rel_s) state_nx = WK_SLEEP;
            default:  state_nx = WK_SLEEP;
        endcase
    end

    always_ff @(posedge pcm_clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (state == WK_COUNT) cnt <= cnt + 1'b1;
        else                       cnt <= '0;
    end

    always_comb begin
        ready = (state == WK_READY);
    end

    // checker counter: cycles the synchronized release has been held
    always_ff @(posedge pcm_clk or negedge rst_n) begin
        if (!rst_n)                                held_cnt <= '0;
        else if (!rel_s)                           held_cnt <= '0;
        else if (held_cnt != CNT_W'(WAKE_CYCLES))  held_cnt <= held_cnt + 1'b1;
    end

    // R7
    wake_gate_chk: assert property (@(posedge pcm_clk) disable iff (!rst_n)
        ready |-> (held_cnt == CNT_W'(WAKE_CYCLES)));
    // R7
    wake_drop_chk: assert property (@(posedge pcm_clk) disable iff (!rst_n)
        !rel_s |=> !ready);
endmodule

// File: rtl/pcm_ctrl_sync.sv
module pcm_ctrl_sync
    import pcm_ctrl_pkg::*;
#(
    parameter int STAGES      = 2,
    parameter int CLR_CYCLES  = 2,
    parameter int WAKE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        port_en,
    output logic        rx_on,
    output logic        tx_on,
    output logic        dma_en,
    output logic [1:0]  rx_thresh,
    output logic [1:0]  tx_thresh,
    input  logic        txf_empty,
    input  logic        txf_space,
    input  logic        txf_low,
    input  logic        rxf_data,
    input  logic        rxf_full,
    input  logic        rxf_high,
    input  logic        tx_syncd,
    input  logic        rx_syncd,
    input  logic        tx_underflow,
    input  logic        rx_overflow,
    input  logic        pcm_clk,
    output logic        pcm_tx_clr,
    output logic        pcm_rx_clr,
    output logic        pcm_ready
);
    localparam int LANES = 2;

    logic en_q, rx_on_q, tx_on_q, dma_q, echo_wr_q, wake_q;
    logic tx_err_q, rx_err_q;
    logic [1:0] rx_thr_q, tx_thr_q;
    logic echo_pcm, echo_rd;
    logic [LANES-1:0] lane_req, lane_pend, lane_clr;
    logic tx_err_set, rx_err_set, tx_err_wipe, rx_err_wipe;
    logic unused_wr;

    assign unused_wr = ^{wr_data[31:26], wr_data[23:17], wr_data[14:10]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            rx_on_q   <= 1'b0;
            tx_on_q   <= 1'b0;
            dma_q     <= 1'b0;
            rx_thr_q  <= '0;
            tx_thr_q  <= '0;
            echo_wr_q <= 1'b0;
            wake_q    <= 1'b0;
        end else if (wr_en) begin
            en_q      <= wr_data[B_EN];
            rx_on_q   <= wr_data[B_RX_RUN];
            tx_on_q   <= wr_data[B_TX_RUN];
            dma_q     <= wr_data[B_DMA];
            rx_thr_q  <= wr_data[B_RX_THR +: 2];
            tx_thr_q  <= wr_data[B_TX_THR +: 2];
            echo_wr_q <= wr_data[B_ECHO];
            wake_q    <= wr_data[B_WAKE];
        end
    end

    assign tx_err_set  = tx_underflow && en_q && tx_on_q;
    assign rx_err_set  = rx_overflow  && en_q && rx_on_q;
    assign tx_err_wipe = wr_en && wr_data[B_TX_FAULT];
    assign rx_err_wipe = wr_en && wr_data[B_RX_FAULT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_err_q <= 1'b0;
            rx_err_q <= 1'b0;
        end else begin
            tx_err_q <= tx_err_set || (tx_err_q && !tx_err_wipe);
            rx_err_q <= rx_err_set || (rx_err_q && !rx_err_wipe);
        end
    end

    // clear lanes: index 0 transmit, index 1 receive
    assign lane_req[0] = wr_en && wr_data[B_TX_FLUSH];
    assign lane_req[1] = wr_en && wr_data[B_RX_FLUSH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcm_clr_lane #(.STAGES(STAGES), .CLR_CYCLES(CLR_CYCLES)) u_lane (
            .clk(clk), .pcm_clk(pcm_clk), .rst_n(rst_n),
            .req(lane_req[g]), .pending(lane_pend[g]), .pcm_clr(lane_clr[g]));
    end

    assign pcm_tx_clr = lane_clr[0];
    assign pcm_rx_clr = lane_clr[1];

    // sync echo round trip
    pcm_bit_sync #(.STAGES(STAGES)) u_echo_out (
        .clk(pcm_clk), .rst_n(rst_n), .d(echo_wr_q), .q(echo_pcm));
    pcm_bit_sync #(.STAGES(STAGES)) u_echo_back (
        .clk(clk), .rst_n(rst_n), .d(echo_pcm), .q(echo_rd));

    pcm_wake_fsm #(.STAGES(STAGES), .WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .pcm_clk(pcm_clk), .rst_n(rst_n), .release_lvl(wake_q), .ready(pcm_ready));

    assign port_en   = en_q;
    assign rx_on     = rx_on_q;
    assign tx_on     = tx_on_q;
    assign dma_en    = dma_q;
    assign rx_thresh = rx_thr_q;
    assign tx_thresh = tx_thr_q;

    always_comb begin
        rd_data               = '0;
        rd_data[B_EN]         = en_q;
        rd_data[B_RX_RUN]     = rx_on_q;
        rd_data[B_TX_RUN]     = tx_on_q;
        rd_data[B_TX_FLUSH]   = lane_pend[0];
        rd_data[B_RX_FLUSH]   = lane_pend[1];
        rd_data[B_TX_THR +: 2] = tx_thr_q;
        rd_data[B_RX_THR +: 2] = rx_thr_q;
        rd_data[B_DMA]        = dma_q;
        rd_data[B_TX_ALIGN]   = tx_syncd;
        rd_data[B_RX_ALIGN]   = rx_syncd;
        rd_data[B_TX_FAULT]   = tx_err_q;
        rd_data[B_RX_FAULT]   = rx_err_q;
        rd_data[B_TX_HUNGRY]  = txf_low;
        rd_data[B_RX_READY]   = rxf_high;
        rd_data[B_TX_ROOM]    = txf_space;
        rd_data[B_RX_AVAIL]   = rxf_data;
        rd_data[B_TX_DRY]     = txf_empty;
        rd_data[B_RX_BRIM]    = rxf_full;
        rd_data[B_ECHO]       = echo_rd;
        rd_data[B_WAKE]       = wake_q;
    end

    // R9
    tx_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_TX_FAULT] && !(wr_en && wr_data[B_TX_FAULT])) |=> rd_data[B_TX_FAULT]);
    // R9
    rx_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[B_RX_FAULT] && !(rx_overflow && port_en && rx_on)) |=> !rd_data[B_RX_FAULT]);
    // R6
    echo_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(echo_pcm) |=> $stable(echo_rd) || $past(echo_rd) != $past(echo_pcm));
endmodule

// File: tb/pcm_ctrl_sync_test.sv
module pcm_ctrl_sync_test;
    logic clk = 0, pcm_clk = 0, pcm_run = 1, rst_n = 0;
    logic wr_en = 0;
    logic [31:0] wr_data = '0, rd_data;
    logic port_en, rx_on, tx_on, dma_en, pcm_tx_clr, pcm_rx_clr, pcm_ready;
    logic [1:0] rx_thresh, tx_thresh;
    logic txf_empty = 0, txf_space = 0, txf_low = 0, rxf_data = 0;
    logic rxf_full = 0, rxf_high = 0, tx_syncd = 0, rx_syncd = 0;
    logic tx_underflow = 0, rx_overflow = 0;
    int compared = 0, mismatched = 0;
    int pcm_edges = 0, tx_pulses = 0, rx_pulses = 0, tx_first = -1;
    bit finished = 0;

    pcm_ctrl_sync uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .port_en(port_en), .rx_on(rx_on), .tx_on(tx_on), .dma_en(dma_en),
        .rx_thresh(rx_thresh), .tx_thresh(tx_thresh),
        .txf_empty(txf_empty), .txf_space(txf_space), .txf_low(txf_low),
        .rxf_data(rxf_data), .rxf_full(rxf_full), .rxf_high(rxf_high),
        .tx_syncd(tx_syncd), .rx_syncd(rx_syncd),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow),
        .pcm_clk(pcm_clk), .pcm_tx_clr(pcm_tx_clr), .pcm_rx_clr(pcm_rx_clr),
        .pcm_ready(pcm_ready));

    always #4 clk = ~clk;
    initial begin
        #3;
        forever begin
            #10;
            if (pcm_run) pcm_clk = ~pcm_clk;
        end
    end

    always @(posedge pcm_clk) pcm_edges++;
    always @(negedge pcm_clk) begin
        if (pcm_tx_clr) begin
            tx_pulses++;
            if (tx_first < 0) tx_first = pcm_edges;
        end
        if (pcm_rx_clr) rx_pulses++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #150000;
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int e0, base, seen;
        logic [31:0] w;
        logic [7:0] st;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 outputs", {24'h0, port_en, rx_on, tx_on, dma_en, rx_thresh, tx_thresh}, 32'h0);
        chk("R1 pcm_ready", {31'h0, pcm_ready}, 32'h0);

        // R2 near-exhaustive sweep of control fields
        for (int k = 0; k < 128; k++) begin
            w = '0;
            w[0] = k[0]; w[1] = k[1]; w[2] = k[2]; w[9] = k[3];
            w[6:5] = k[5:4]; w[8:7] = {k[6], k[0] ^ k[1]};
            wr(w);
            chk("R2 readback", rd_data & 32'h3E7, w);
            chk("R2 outputs", {24'h0, port_en, rx_on, tx_on, dma_en, rx_thresh, tx_thresh},
                {24'h0, w[0], w[1], w[2], w[9], w[8:7], w[6:5]});
        end

        // R3 independent run bits
        wr(32'h7);
        wr(32'h3);
        chk("R3 rx kept", {30'h0, rx_on, tx_on}, 32'h2);
        wr(32'h5);
        chk("R3 tx kept", {30'h0, rx_on, tx_on}, 32'h1);

        // R8 status sweep
        for (int k = 0; k < 256; k++) begin
            st = k[7:0];
            @(negedge clk);
            {txf_empty, txf_space, txf_low, rxf_data, rxf_full, rxf_high, tx_syncd, rx_syncd} = st;
            #1;
            w = '0;
            w[21] = st[7]; w[19] = st[6]; w[17] = st[5]; w[20] = st[4];
            w[22] = st[3]; w[18] = st[2]; w[13] = st[1]; w[14] = st[0];
            chk("R8 status", rd_data & 32'h007E6000, w);
        end
        @(negedge clk);
        {txf_empty, txf_space, txf_low, rxf_data, rxf_full, rxf_high, tx_syncd, rx_syncd} = '0;

        // R4 transmit clear
        wr(32'h1);
        base = tx_pulses;
        e0 = pcm_edges;
        wr(32'h9);
        chk("R4 tx pending set", {31'h0, rd_data[3]}, 32'h1);
        for (int n = 0; n < 400 && rd_data[3]; n++) @(negedge clk);
        chk("R4 tx self-clear", {31'h0, rd_data[3]}, 32'h0);
        chk("R4 tx one pulse", tx_pulses - base, 1);
        chk("R4 tx delay>=4", {31'h0, (tx_first - e0) >= 4}, 32'h1);
        // R4 receive clear
        base = rx_pulses;
        wr(32'h11);
        chk("R4 rx pending set", {31'h0, rd_data[4]}, 32'h1);
        for (int n = 0; n < 400 && rd_data[4]; n++) @(negedge clk);
        chk("R4 rx self-clear", {31'h0, rd_data[4]}, 32'h0);
        chk("R4 rx one pulse", rx_pulses - base, 1);
        // R4 writing zero produces nothing
        base = tx_pulses + rx_pulses;
        wr(32'h1);
        idle(60);
        chk("R4 zero no pulse", tx_pulses + rx_pulses - base, 0);

        // R5 clock stopped keeps the request pending
        pcm_run = 0;
        idle(4);
        base = tx_pulses;
        wr(32'h9);
        idle(100);
        chk("R5 still pending", {31'h0, rd_data[3]}, 32'h1);
        chk("R5 no pulse", tx_pulses - base, 0);
        pcm_run = 1;
        for (int n = 0; n < 400 && rd_data[3]; n++) @(negedge clk);
        chk("R5 completes", {31'h0, rd_data[3]}, 32'h0);
        chk("R5 one pulse", tx_pulses - base, 1);

        // R6 sync echo
        e0 = pcm_edges;
        wr(32'h0100_0001);
        chk("R6 not yet", {31'h0, rd_data[24]}, 32'h0);
        seen = 0;
        for (int n = 0; n < 400 && !rd_data[24]; n++) @(negedge clk);
        seen = pcm_edges - e0;
        chk("R6 echo arrives", {31'h0, rd_data[24]}, 32'h1);
        chk("R6 echo >=2 edges", {31'h0, seen >= 2}, 32'h1);
        pcm_run = 0;
        idle(4);
        wr(32'h1);
        idle(100);
        chk("R6 frozen", {31'h0, rd_data[24]}, 32'h1);
        pcm_run = 1;
        for (int n = 0; n < 400 && rd_data[24]; n++) @(negedge clk);
        chk("R6 resumes", {31'h0, rd_data[24]}, 32'h0);

        // R7 standby release
        e0 = pcm_edges;
        wr(32'h0200_0001);
        for (int n = 0; n < 400 && !pcm_ready; n++) @(negedge clk);
        seen = pcm_edges - e0;
        chk("R7 ready", {31'h0, pcm_ready}, 32'h1);
        chk("R7 ready >=6 edges", {31'h0, seen >= 6}, 32'h1);
        e0 = pcm_edges;
        wr(32'h1);
        for (int n = 0; n < 400 && pcm_ready; n++) @(negedge clk);
        chk("R7 drops", {31'h0, pcm_ready}, 32'h0);
        chk("R7 drop timely", {31'h0, (pcm_edges - e0) <= 6}, 32'h1);

        // R9 sticky errors
        wr(32'h7);
        @(negedge clk); tx_underflow = 1;
        @(negedge clk); tx_underflow = 0;
        chk("R9 tx set", {31'h0, rd_data[15]}, 32'h1);
        wr(32'h7);
        chk("R9 tx sticky on write 0", {31'h0, rd_data[15]}, 32'h1);
        wr(32'h0000_8007);
        chk("R9 tx cleared", {31'h0, rd_data[15]}, 32'h0);
        wr(32'h3);
        @(negedge clk); tx_underflow = 1;
        @(negedge clk); tx_underflow = 0;
        chk("R9 tx ignored when off", {31'h0, rd_data[15]}, 32'h0);
        @(negedge clk); rx_overflow = 1;
        @(negedge clk); rx_overflow = 0;
        chk("R9 rx set", {31'h0, rd_data[16]}, 32'h1);
        @(negedge clk); rx_overflow = 1; wr_en = 1; wr_data = 32'h0001_0003;
        @(negedge clk); rx_overflow = 0; wr_en = 0; wr_data = '0;
        chk("R9 set beats clear", {31'h0, rd_data[16]}, 32'h1);
        wr(32'h0001_0003);
        chk("R9 rx cleared", {31'h0, rd_data[16]}, 32'h0);
        wr(32'h4);
        @(negedge clk); rx_overflow = 1;
        @(negedge clk); rx_overflow = 0;
        chk("R9 rx ignored when off", {31'h0, rd_data[16]}, 32'h0);
        wr(32'h6);
        @(negedge clk); tx_underflow = 1; rx_overflow = 1;
        @(negedge clk); tx_underflow = 0; rx_overflow = 0;
        chk("R9 ignored when port disabled", {30'h0, rd_data[16], rd_data[15]}, 32'h0);

        finish_run();
    end
endmodule